// File: doc/BRIEF.md
# Graphic LCD Text Sequencer

This block brings up a 128x64 monochrome graphic LCD controller and then draws a fixed string of text on it, with no processor involved. It talks to the controller over an 8-bit write-only parallel bus in 6800 style: an active-low select, an enable strobe, a read/write line held at write, and a data/instruction line.

After reset it plays a start-up script held in an internal 10-bit-wide ROM. Bit 9 of each word marks it as an instruction or as display data, and bit 8 asks for a long pause once that word has gone out. The pause lets the panel's supplies settle after the word that switches the display into operational mode.

It then walks a text ROM one character at a time. For each character it sends three address instructions: the line (page) and the column split into high and low nibbles. Eight glyph bytes follow. They are fetched from a character ROM at a fixed base plus the character code shifted left by three. A character-position counter and a line counter advance after every glyph. When the last character is drawn a done flag rises, and the block stays idle until reset.

Top module: `glcd_text_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `lcd_csn` is 1, `lcd_en` is 0 and `done` is 0.
- R2: Bus transfer timing:
  - `lcd_csn` is low and `lcd_di`/`lcd_db` are valid for at least `T_SETUP` cycles before `lcd_en` rises.
  - `lcd_en` stays high for exactly `T_EN` cycles, with `lcd_csn` low and `lcd_rw` 0 (write).
  - `lcd_di`/`lcd_db` do not change while `lcd_en` is high, nor for at least `T_HOLD` cycles after it falls.
- R3: The first 14 transfers after reset are the start-up script, in this order: E2, A0, C0, A2, 2F, 24, 81, 20, 40, AF, B0, 10, 00 as instructions, then one display-data byte 00. A script word with bit 9 = 1 goes out with `lcd_di` = 0 (instruction). A word with bit 9 = 0 goes out with `lcd_di` = 1 (data).
- R4: The script word 2F (the fifth transfer) has bit 8 set. From the falling edge of its enable pulse to the rising edge of the next enable, at least `WAIT_CYCLES` clock cycles pass.
- R5: The two-byte reference-voltage instruction goes out as 81 immediately followed by 20, with no transfer between them.
- R6: Each character first sends three instructions:
  - B0 OR line;
  - 10 OR (column >> 4);
  - column AND 0F.
  
  Here column = 8 × (character position within the line).
- R7: Each character then sends eight data transfers, rows 0 to 7 in order. Row r reads character-ROM address a = `GLYPH_BASE` + 8 × code + r. The byte at address a is (37 × a + 11) mod 256, so code 58h with base 348 starts at address 1052, byte 17h.
- R8: Character i has code 20h + ((13 × i + 56) mod 96). The position advances per character and wraps at `CHARS_PER_LINE` to 0 while the line increments. The line wraps at `LINES` to 0.
- R9: After the last glyph byte of character `NUM_CHARS`-1, `done` rises. No further enable pulse occurs and `done` stays 1 until reset. The total is 14 + 11 × `NUM_CHARS` transfers.
- R10: A reset in the middle of a run abandons it, and the next transfer is script word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lcd_db | output | 8 | Parallel data byte to the controller |
| lcd_csn | output | 1 | Chip select, active low |
| lcd_en | output | 1 | Enable strobe, active high |
| lcd_rw | output | 1 | Read/write select, held at 0 (write) |
| lcd_di | output | 1 | 1 = display data, 0 = instruction |
| done | output | 1 | Whole string written |

## Verification
The bench builds the block with the following parameters:

| Parameter | Bench value |
|-----------|-------------|
| `WAIT_CYCLES` | 40 |
| `T_SETUP` | 1 |
| `T_EN` | 2 |
| `T_HOLD` | 1 |
| `T_GAP` | 1 |
| `NUM_CHARS` | 20 |
| `CHARS_PER_LINE` | 16 |
| `LINES` | 8 |
| `GLYPH_BASE` | 348 |

The short pause and one-cycle bus phases make a full run of 234 transfers short enough to repeat after several resets at seeded random points. With 20 characters on 16 per line, the string wraps onto the second line, so the position wrap and the line increment both show up in the address instructions. The first character is 58h, which places the directed glyph-address case at the very start of the text.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    typedef enum logic [2:0] {
        B_IDLE,
        B_SETUP,
        B_STROBE,
        B_HOLD,
        B_GAP
    } bus_state_e;

    typedef enum logic [2:0] {
        Q_SCRIPT,
        Q_WAIT,
        Q_CHAR,
        Q_FIN,
        Q_DONE
    } seq_state_e;

    // One bus transfer: data/instruction flag plus the byte.
    typedef struct packed {
        logic       is_data;
        logic [7:0] val;
    } xfer_t;

    localparam int SCRIPT_LEN = 14;
    localparam int STEPS_PER_CHAR = 11; // 3 address instructions + 8 glyph rows
    localparam logic [7:0] CMD_PAGE   = 8'hB0;
    localparam logic [7:0] CMD_COL_HI = 8'h10;
    localparam logic [7:0] CMD_COL_LO = 8'h00;

    // Script word: [9] 1 = instruction, [8] 1 = pause afterwards, [7:0] byte.
    function automatic logic [9:0] script_word(input int unsigned i);
        case (i)
            0:       return {2'b10, 8'hE2};
            1:       return {2'b10, 8'hA0};
            2:       return {2'b10, 8'hC0};
            3:       return {2'b10, 8'hA2};
            4:       return {2'b11, 8'h2F};
            5:       return {2'b10, 8'h24};
            6:       return {2'b10, 8'h81};
            7:       return {2'b10, 8'h20};
            8:       return {2'b10, 8'h40};
            9:       return {2'b10, 8'hAF};
            10:      return {2'b10, 8'hB0};
            11:      return {2'b10, 8'h10};
            12:      return {2'b10, 8'h00};
            13:      return {2'b00, 8'h00};
            default: return {2'b10, 8'hE3};
        endcase
    endfunction

    function automatic logic [7:0] text_code(input int unsigned i);
        return 8'(32 + ((i * 13 + 56) % 96));
    endfunction

    function automatic logic [7:0] glyph_byte(input int unsigned a);
        int unsigned v;
        v = a * 37 + 11;
        return v[7:0];
    endfunction

endpackage

// File: rtl/glcd_bus6800.sv
module glcd_bus6800
    import glcd_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_EN    = 4,
    parameter int T_HOLD  = 2,
    parameter int T_GAP   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  xfer_t       req,
    output logic        ready,
    output logic        csn,
    output logic        en,
    output logic        rw,
    output logic        di,
    output logic [7:0]  db
);
    localparam int TM1  = (T_SETUP > T_EN) ? T_SETUP : T_EN;
    localparam int TM2  = (T_HOLD > T_GAP) ? T_HOLD : T_GAP;
    localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
    localparam int CW   = $clog2(TMAX + 1);

    bus_state_e    st_q;
    logic [CW-1:0] cnt_q;
    xfer_t         lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= B_IDLE;
            cnt_q <= '0;
            lat_q <= '0;
        end else begin
            case (st_q)
                B_IDLE: if (start) begin
                    lat_q <= req;
                    st_q  <= B_SETUP;
                    cnt_q <= CW'(T_SETUP - 1);
                end
                B_SETUP: if (cnt_q == '0) begin
                    st_q  <= B_STROBE;
                    cnt_q <= CW'(T_EN - 1);
                end else cnt_q <= cnt_q - 1'b1;
                B_STROBE: if (cnt_q == '0) begin
                    st_q  <= B_HOLD;
                    cnt_q <= CW'(T_HOLD - 1);
                end else cnt_q <= cnt_q - 1'b1;
                B_HOLD: if (cnt_q == '0) begin
                    st_q  <= B_GAP;
                    cnt_q <= CW'(T_GAP - 1);
                end else cnt_q <= cnt_q - 1'b1;
                B_GAP: if (cnt_q == '0) begin
                    st_q <= B_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: st_q <= B_IDLE;
            endcase
        end
    end

    assign ready = (st_q == B_IDLE);
    assign csn   = !((st_q == B_SETUP) || (st_q == B_STROBE) || (st_q == B_HOLD));
    assign en    = (st_q == B_STROBE);
    assign rw    = 1'b0;
    assign di    = lat_q.is_data;
    assign db    = lat_q.val;

endmodule

// File: rtl/glcd_script_rom.sv
module glcd_script_rom
    import glcd_pkg::*;
#(
    parameter int AW = $clog2(SCRIPT_LEN)
) (
    input  logic [AW-1:0] addr,
    output logic          is_instr,
    output logic          pause_after,
    output logic [7:0]    val
);
    logic [9:0] word;

    always_comb begin
        word        = script_word(int'(addr));
        is_instr    = word[9];
        pause_after = word[8];
        val         = word[7:0];
    end

endmodule

// File: rtl/glcd_text_rom.sv
module glcd_text_rom
    import glcd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] idx,
    output logic [7:0]    code
);
    always_comb code = text_code(int'(idx));

endmodule

// File: rtl/glcd_glyph_rom.sv
module glcd_glyph_rom
    import glcd_pkg::*;
#(
    parameter int BASE = 348
) (
    input  logic [7:0] code,
    input  logic [2:0] row,
    output logic [7:0] bits
);
    localparam int AW = $clog2(BASE + 2048);

    logic [AW-1:0] addr;

    always_comb begin
        addr = AW'(BASE) + AW'({code, row}); // base + (code << 3) + row
        bits = glyph_byte(int'(addr));
    end

endmodule

// File: rtl/glcd_text_seq.sv
module glcd_text_seq
    import glcd_pkg::*;
#(
    parameter int NUM_CHARS      = 20,
    parameter int CHARS_PER_LINE = 16,
    parameter int LINES          = 8,
    parameter int GLYPH_BASE     = 348,
    parameter int WAIT_CYCLES    = 50000,
    parameter int T_SETUP        = 2,
    parameter int T_EN           = 4,
    parameter int T_HOLD         = 2,
    parameter int T_GAP          = 2
) (
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] lcd_db,
    output logic       lcd_csn,
    output logic       lcd_en,
    output logic       lcd_rw,
    output logic       lcd_di,
    output logic       done
);
    localparam int SIW = $clog2(SCRIPT_LEN);
    localparam int CIW = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1;
    localparam int PW  = (CHARS_PER_LINE > 1) ? $clog2(CHARS_PER_LINE) : 1;
    localparam int LW  = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int WW  = $clog2(WAIT_CYCLES + 1);
    localparam logic [3:0] LAST_STEP = 4'(STEPS_PER_CHAR - 1);

    seq_state_e     st_q;
    logic [SIW-1:0] sidx_q;
    logic [WW-1:0]  wcnt_q;
    logic [CIW-1:0] chr_q;
    logic [PW-1:0]  pos_q;
    logic [LW-1:0]  line_q;
    logic [3:0]     step_q;
    logic           done_q;

    logic       s_instr, s_pause;
    logic [7:0] s_val;
    logic [7:0] code, glyph;
    logic [7:0] col_px;
    logic       ready, start;
    xfer_t      req;

    glcd_script_rom #(.AW(SIW)) u_script (
        .addr(sidx_q), .is_instr(s_instr), .pause_after(s_pause), .val(s_val)
    );

    glcd_text_rom #(.AW(CIW)) u_text (.idx(chr_q), .code(code));

    glcd_glyph_rom #(.BASE(GLYPH_BASE)) u_glyph (
        .code(code), .row(3'(step_q - 4'd3)), .bits(glyph)
    );

    glcd_bus6800 #(
        .T_SETUP(T_SETUP), .T_EN(T_EN), .T_HOLD(T_HOLD), .T_GAP(T_GAP)
    ) u_bus (
        .clk(clk), .rst(rst), .start(start), .req(req), .ready(ready),
        .csn(lcd_csn), .en(lcd_en), .rw(lcd_rw), .di(lcd_di), .db(lcd_db)
    );

    always_comb begin
        col_px = 8'({pos_q, 3'b000});
        req    = '0;
        start  = 1'b0;
        case (st_q)
            Q_SCRIPT: begin
                req.is_data = !s_instr;
                req.val     = s_val;
                start       = ready;
            end
            Q_CHAR: begin
                start = ready;
                case (step_q)
                    4'd0: req.val = CMD_PAGE | 8'(line_q);
                    4'd1: req.val = CMD_COL_HI | {4'h0, col_px[7:4]};
                    4'd2: req.val = CMD_COL_LO | {4'h0, col_px[3:0]};
                    default: begin
                        req.is_data = 1'b1;
                        req.val     = glyph;
                    end
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= Q_SCRIPT;
            sidx_q <= '0;
            wcnt_q <= '0;
            chr_q  <= '0;
            pos_q  <= '0;
            line_q <= '0;
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            case (st_q)
                Q_SCRIPT: if (ready) begin
                    sidx_q <= sidx_q + 1'b1;
                    if (s_pause) begin
                        st_q   <= Q_WAIT;
                        wcnt_q <= '0;
                    end else if (sidx_q == SIW'(SCRIPT_LEN - 1)) begin
                        st_q <= Q_CHAR;
                    end
                end
                Q_WAIT: if (ready) begin
                    if (wcnt_q == WW'(WAIT_CYCLES - 1)) st_q <= Q_SCRIPT;
                    else wcnt_q <= wcnt_q + 1'b1;
                end
                Q_CHAR: if (ready) begin
                    if (step_q == LAST_STEP) begin
                        step_q <= '0;
                        if (chr_q == CIW'(NUM_CHARS - 1)) st_q <= Q_FIN;
                        else chr_q <= chr_q + 1'b1;
                        if (pos_q == PW'(CHARS_PER_LINE - 1)) begin
                            pos_q  <= '0;
                            line_q <= (line_q == LW'(LINES - 1)) ? '0 : line_q + 1'b1;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                Q_FIN: if (ready) begin
                    done_q <= 1'b1;
                    st_q   <= Q_DONE;
                end
                default: ;
            endcase
        end
    end

    assign done = done_q;

endmodule

// File: rtl/glcd_text_seq_chk.sv
module glcd_text_seq_chk #(
    parameter int T_EN = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       csn,
    input logic       en,
    input logic       rw,
    input logic       di,
    input logic [7:0] db,
    input logic       done
);
    localparam int CW = $clog2(T_EN + 1);

    logic [CW-1:0] en_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) en_cnt <= '0;
        else            en_cnt <= en_cnt + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (csn && !en && !done));

    p_en_in_cs_r2: assert property (@(posedge clk) disable iff (rst)
        en |-> !csn);

    p_write_only_r2: assert property (@(posedge clk) disable iff (rst)
        en |-> !rw);

    p_strobe_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> $stable({di, db}));

    p_en_not_long_r2: assert property (@(posedge clk) disable iff (rst)
        en |-> (en_cnt < CW'(T_EN)));

    p_en_full_width_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |-> ($past(en_cnt) == CW'(T_EN - 1)));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (csn && !en));

endmodule

bind glcd_text_seq glcd_text_seq_chk #(.T_EN(T_EN)) u_chk (
    .clk(clk), .rst(rst), .csn(lcd_csn), .en(lcd_en), .rw(lcd_rw),
    .di(lcd_di), .db(lcd_db), .done(done)
);

// File: tb/glcd_text_seq_bench.sv
module glcd_text_seq_bench;
    localparam int NCH = 20, CPL = 16, NL = 8, BASE = 348, WAITC = 40;
    localparam int TS = 1, TE = 2, TH = 1, TG = 1;
    localparam int TOTAL = 14 + 11 * NCH;
    localparam int SEED = 1234;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] lcd_db;
    logic lcd_csn, lcd_en, lcd_rw, lcd_di, done;

    always #10 clk = ~clk; // 50 MHz

    glcd_text_seq #(
        .NUM_CHARS(NCH), .CHARS_PER_LINE(CPL), .LINES(NL), .GLYPH_BASE(BASE),
        .WAIT_CYCLES(WAITC), .T_SETUP(TS), .T_EN(TE), .T_HOLD(TH), .T_GAP(TG)
    ) u_glcd_text_seq (
        .clk(clk), .rst(rst), .lcd_db(lcd_db), .lcd_csn(lcd_csn), .lcd_en(lcd_en),
        .lcd_rw(lcd_rw), .lcd_di(lcd_di), .done(done)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Expected {di, db} of transfer k, from the requirements.
    function automatic logic [8:0] exp_word(input int k);
        int j, c, s, pos, line, col, code;
        logic [7:0] sb;
        logic instr;
        if (k < 14) begin
            instr = 1'b1;
            case (k)
                0: sb = 8'hE2;  1: sb = 8'hA0;  2: sb = 8'hC0;  3: sb = 8'hA2;
                4: sb = 8'h2F;  5: sb = 8'h24;  6: sb = 8'h81;  7: sb = 8'h20;
                8: sb = 8'h40;  9: sb = 8'hAF;  10: sb = 8'hB0; 11: sb = 8'h10;
                12: sb = 8'h00;
                default: begin sb = 8'h00; instr = 1'b0; end
            endcase
            return {!instr, sb};
        end
        j = k - 14; c = j / 11; s = j % 11;
        pos = c % CPL; line = (c / CPL) % NL; col = pos * 8;
        code = 32 + ((c * 13 + 56) % 96);
        case (s)
            0: return {1'b0, 8'(8'hB0 | line)};
            1: return {1'b0, 8'(8'h10 | (col >> 4))};
            2: return {1'b0, 8'(col & 15)};
            default: return {1'b1, 8'(((BASE + code * 8 + (s - 3)) * 37 + 11) % 256)};
        endcase
    endfunction

    function automatic string tag_of(input int k, input bit restarted);
        int j;
        if (restarted && k == 0) return "R10";
        if (k == 6 || k == 7) return "R5";
        if (k < 14) return "R3";
        j = k - 14;
        if ((j % 11) >= 3) return "R7";
        if ((j / 11) >= CPL) return "R8";
        return "R6";
    endfunction

    // Bus monitor
    int k = 0, setup_n = 0, en_n = 0, hold_n = 0, fall_cyc = 0;
    bit en_prev = 0, in_hold = 0, restarted = 0;
    logic [8:0] cap;

    always @(negedge clk) begin
        if (rst) begin
            k = 0; setup_n = 0; en_n = 0; hold_n = 0; en_prev = 0; in_hold = 0;
        end else begin
            if (lcd_en && !en_prev) begin
                chk(setup_n >= TS, "R2 setup", setup_n, TS);
                chk(lcd_rw == 1'b0, "R2 rw", lcd_rw, 0);
                if (k >= TOTAL) begin
                    chk(0, "R9 transfer after end", k, TOTAL);
                end else begin
                    chk({lcd_di, lcd_db} == exp_word(k), tag_of(k, restarted),
                        {lcd_di, lcd_db}, exp_word(k));
                    if (k == 5) chk(cyc - fall_cyc >= WAITC, "R4 pause", cyc - fall_cyc, WAITC);
                    if (k == 0) restarted = 0;
                end
                cap = {lcd_di, lcd_db};
                en_n = 1;
                k++;
            end else if (lcd_en) begin
                en_n++;
                if ({lcd_di, lcd_db} != cap) chk(0, "R2 stable", {lcd_di, lcd_db}, cap);
            end else if (en_prev) begin
                chk(en_n == TE, "R2 width", en_n, TE);
                fall_cyc = cyc;
                in_hold = 1; hold_n = 0;
            end
            if (in_hold) begin
                if (!lcd_csn) begin
                    if ({lcd_di, lcd_db} == cap) hold_n++;
                end else begin
                    chk(hold_n >= TH, "R2 hold", hold_n, TH);
                    in_hold = 0;
                end
            end
            if (lcd_csn || lcd_en) setup_n = 0;
            else if (!in_hold) setup_n++;
            en_prev = lcd_en;
        end
    end

    task automatic check_idle(input string tag);
        chk(lcd_csn == 1'b1, tag, lcd_csn, 1);
        chk(lcd_en == 1'b0, tag, lcd_en, 0);
        chk(done == 1'b0, tag, done, 0);
    endtask

    initial begin
        int n;
        void'($urandom(SEED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 reset");
        rst = 1'b0;
        // Random mid-run resets (R10)
        for (int r = 0; r < 3; r++) begin
            n = 60 + int'($urandom % 900);
            repeat (n) @(negedge clk);
            rst = 1'b1;
            restarted = 1;
            repeat (2) @(negedge clk);
            check_idle("R1 reset mid-run");
            rst = 1'b0;
        end
        // Directed: first glyph byte of code 58h at base 348 is 17h (R7)
        chk(exp_word(14 + 3) == 9'h117, "R7 directed", exp_word(17), 9'h117);
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        chk(done == 1'b1, "R9 done", done, 1);
        chk(k == TOTAL, "R9 count", k, TOTAL);
        repeat (60) @(negedge clk);
        chk(done == 1'b1, "R9 sticky", done, 1);
        chk(k == TOTAL, "R9 quiet", k, TOTAL);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule